// File: doc/BRIEF.md
# Posted-Write Buffer with Interrupt Ordering

This block sits inside a bus bridge and separates write traffic on the source bus from write traffic on the destination bus. A write on the source side carries an address, 32 data bits and four byte enables. The buffer stores the write and acknowledges it in the same cycle, so the source bus is free again at once. On the destination side the buffer presents the oldest stored write to a simple bus master through a valid/ready handshake. The stored writes leave in the order they arrived. Each presented beat carries a flag that shows whether the following stored entry continues a sequential burst.

An interrupt that crosses the bridge must not overtake data that was posted ahead of it. When the block captures an interrupt, it records how many writes are waiting at that moment. The gated interrupt output stays low until that many writes have drained. An interrupt-acknowledge access from the source side receives wait states until the buffer is empty. The block also reports status: empty, full and the number of stored entries.

Top module: `posted_write_buffer`

## Requirements
- R1: While fewer than DEPTH entries are stored, a write request (`src_wr_valid` high) is acknowledged combinationally in the same cycle and stored at that clock edge.
- R2: While DEPTH entries are stored and no entry drains in that cycle, `src_wr_ack` stays low, the write is not stored and `stat_count` does not change.
- R3: While the buffer is full, a write that arrives in a cycle where an entry drains (`dst_valid` and `dst_ready` both high) is acknowledged and stored, and the count stays at DEPTH.
- R4: An entry is removed only in a cycle where `dst_valid` and `dst_ready` are both high. Entries appear on `dst_addr`, `dst_data` and `dst_be` unchanged and in acceptance order, each exactly once.
- R5: While `dst_valid` is high and `dst_ready` is low, `dst_valid`, `dst_addr`, `dst_data` and `dst_be` hold their values into the next cycle.
- R6: `dst_last` is 1 when the presented entry is the only one stored, or when the next stored entry's address is not the presented address plus 4. Otherwise it is 0.
- R7: A high level on `irq_in` while no interrupt is armed arms one and records how many entries are stored, less one if an entry drains in that cycle. `irq_out` goes high once that many entries have drained. Writes accepted after that point do not delay it.
- R8: When `irq_in` is sampled low, the armed interrupt clears and `irq_out` is low in the next cycle.
- R9: `src_iack_ack` is high only while `src_iack_req` is high and the buffer is empty. Otherwise the acknowledge access is held in wait states.
- R10: `stat_empty` is 1 exactly when `stat_count` is 0, `stat_full` is 1 exactly when `stat_count` equals DEPTH, and `stat_count` equals the number of stored entries.
- R11: A synchronous active-high `rst` empties the buffer and clears the interrupt state. After reset, `stat_count` is 0, `stat_empty` is 1, and `dst_valid` and `irq_out` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_wr_valid | input | 1 | Source write request |
| src_wr_addr | input | 32 | Source write address |
| src_wr_data | input | 32 | Source write data |
| src_wr_be | input | 4 | Source byte enables |
| src_wr_ack | output | 1 | Write stored in this cycle |
| src_iack_req | input | 1 | Interrupt-acknowledge access pending |
| src_iack_ack | output | 1 | Interrupt-acknowledge completes |
| dst_valid | output | 1 | A stored write is presented |
| dst_ready | input | 1 | Destination takes the presented write |
| dst_addr | output | 32 | Presented address |
| dst_data | output | 32 | Presented data |
| dst_be | output | 4 | Presented byte enables |
| dst_last | output | 1 | Presented beat ends a sequential burst |
| irq_in | input | 1 | Level interrupt arriving at the bridge |
| irq_out | output | 1 | Interrupt after the earlier writes have drained |
| stat_empty | output | 1 | No entries stored |
| stat_full | output | 1 | DEPTH entries stored |
| stat_count | output | CNT_W (4 at default) | Number of stored entries |

## Verification
The assertions assume that the source bus never issues a write and an interrupt-acknowledge in the same cycle, because both accesses come from one bus. They also assume that `irq_in` is a level that stays high until it is serviced. The destination may drive `dst_ready` in any pattern, and the bench toggles it both in directed steps and in a repeating pattern alongside writes. The bench changes inputs only at the falling clock edge. It keeps write posting and the interrupt-acknowledge access in separate phases, so the single-bus assumption holds throughout.

// File: rtl/pwb_pkg.sv
package pwb_pkg;
  parameter int PWB_ADDR_W     = 32;
  parameter int PWB_DATA_W     = 32;
  parameter int PWB_BE_W       = PWB_DATA_W / 8;
  parameter int PWB_BEAT_BYTES = PWB_DATA_W / 8;

  typedef struct packed {
    logic [PWB_ADDR_W-1:0] addr;
    logic [PWB_DATA_W-1:0] data;
    logic [PWB_BE_W-1:0]   be;
  } pwb_entry_t;
endpackage

// File: rtl/pwb_fifo.sv
module pwb_fifo
  import pwb_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             push,
  input  logic             pop,
  input  pwb_entry_t       wr_entry,
  output pwb_entry_t       head_entry,
  output pwb_entry_t       next_entry,
  output logic [CNT_W-1:0] count,
  output logic             empty,
  output logic             full
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  pwb_entry_t       mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr, rd_ptr_nx;

  function automatic logic [PTR_W-1:0] wrap_inc(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  // storage without reset so the array maps onto device RAM
  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= wr_entry;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push) wr_ptr <= wrap_inc(wr_ptr);
      if (pop)  rd_ptr <= wrap_inc(rd_ptr);
      case ({push, pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  always_comb begin
    rd_ptr_nx  = wrap_inc(rd_ptr);
    head_entry = mem[rd_ptr];
    next_entry = mem[rd_ptr_nx];
    empty      = (count == '0);
    full       = (count == CNT_W'(DEPTH));
  end

  // R2: the acceptance logic never pushes into a full store unless a slot frees
  p_no_overflow_r2: assert property (@(posedge clk) disable iff (rst)
    push |-> (!full || pop));
  // R4: nothing is removed from an empty store
  p_no_underflow_r4: assert property (@(posedge clk) disable iff (rst)
    pop |-> !empty);
  // R10: occupancy never exceeds the depth
  p_count_bound_r10: assert property (@(posedge clk) disable iff (rst)
    count <= CNT_W'(DEPTH));
endmodule

// File: rtl/pwb_burst_mark.sv
module pwb_burst_mark
  import pwb_pkg::*;
#(
  parameter int CNT_W = 4
) (
  input  logic [PWB_ADDR_W-1:0] head_addr,
  input  logic [PWB_ADDR_W-1:0] next_addr,
  input  logic [CNT_W-1:0]      count,
  output logic                  last
);
  localparam logic [PWB_ADDR_W-1:0] STEP = PWB_ADDR_W'(PWB_BEAT_BYTES);

  always_comb begin
    last = (count < CNT_W'(2)) || (next_addr != head_addr + STEP);
  end
endmodule

// File: rtl/pwb_irq_gate.sv
module pwb_irq_gate #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             irq_in,
  input  logic             pop,
  input  logic [CNT_W-1:0] count,
  output logic             irq_out
);
  logic             armed;
  logic [CNT_W-1:0] ahead;

  always_ff @(posedge clk) begin
    if (rst) begin
      armed <= 1'b0;
      ahead <= '0;
    end else if (!irq_in) begin
      armed <= 1'b0;
      ahead <= '0;
    end else if (!armed) begin
      armed <= 1'b1;
      ahead <= count - CNT_W'(pop);
    end else if (pop && ahead != '0) begin
      ahead <= ahead - 1'b1;
    end
  end

  always_comb irq_out = armed && (ahead == '0);

  // R7: the gated interrupt only rises while the incoming interrupt was present
  p_irq_after_input_r7: assert property (@(posedge clk) disable iff (rst)
    $rose(irq_out) |-> $past(irq_in));
  // R8: a low input withdraws the gated interrupt by the next cycle
  p_irq_drop_r8: assert property (@(posedge clk) disable iff (rst)
    !irq_in |=> !irq_out);
endmodule

// File: rtl/posted_write_buffer.sv
module posted_write_buffer
  import pwb_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  src_wr_valid,
  input  logic [PWB_ADDR_W-1:0] src_wr_addr,
  input  logic [PWB_DATA_W-1:0] src_wr_data,
  input  logic [PWB_BE_W-1:0]   src_wr_be,
  output logic                  src_wr_ack,
  input  logic                  src_iack_req,
  output logic                  src_iack_ack,
  output logic                  dst_valid,
  input  logic                  dst_ready,
  output logic [PWB_ADDR_W-1:0] dst_addr,
  output logic [PWB_DATA_W-1:0] dst_data,
  output logic [PWB_BE_W-1:0]   dst_be,
  output logic                  dst_last,
  input  logic                  irq_in,
  output logic                  irq_out,
  output logic                  stat_empty,
  output logic                  stat_full,
  output logic [CNT_W-1:0]      stat_count
);
  pwb_entry_t       wr_e, head_e, next_e;
  logic             push, pop, empty, full;
  logic [CNT_W-1:0] count;

  always_comb begin
    wr_e         = '{addr: src_wr_addr, data: src_wr_data, be: src_wr_be};
    dst_valid    = !empty;
    pop          = dst_valid && dst_ready;
    src_wr_ack   = src_wr_valid && (!full || pop);
    push         = src_wr_ack;
    src_iack_ack = src_iack_req && empty;
    dst_addr     = head_e.addr;
    dst_data     = head_e.data;
    dst_be       = head_e.be;
    stat_empty   = empty;
    stat_full    = full;
    stat_count   = count;
  end

  pwb_fifo #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_store (
    .clk        (clk),
    .rst        (rst),
    .push       (push),
    .pop        (pop),
    .wr_entry   (wr_e),
    .head_entry (head_e),
    .next_entry (next_e),
    .count      (count),
    .empty      (empty),
    .full       (full)
  );

  pwb_burst_mark #(.CNT_W(CNT_W)) u_burst (
    .head_addr (head_e.addr),
    .next_addr (next_e.addr),
    .count     (count),
    .last      (dst_last)
  );

  pwb_irq_gate #(.CNT_W(CNT_W)) u_irq (
    .clk     (clk),
    .rst     (rst),
    .irq_in  (irq_in),
    .pop     (pop),
    .count   (count),
    .irq_out (irq_out)
  );

  // R5: a presented beat waits unchanged while the destination stalls
  p_hold_stable_r5: assert property (@(posedge clk) disable iff (rst)
    (dst_valid && !dst_ready) |=> (dst_valid && $stable(dst_addr) &&
                                   $stable(dst_data) && $stable(dst_be)));
  // R6: a beat not marked last is followed by the sequential address
  p_burst_seq_r6: assert property (@(posedge clk) disable iff (rst)
    (dst_valid && dst_ready && !dst_last) |=>
      (dst_valid && dst_addr == $past(dst_addr) + PWB_ADDR_W'(PWB_BEAT_BYTES)));
  // R9: the acknowledge access completes only with nothing left to drain
  p_iack_wait_r9: assert property (@(posedge clk) disable iff (rst)
    src_iack_ack |-> !dst_valid);
endmodule

// File: tb/posted_write_buffer_bench.sv
`timescale 1ns/1ps
module posted_write_buffer_bench;
  import pwb_pkg::*;
  localparam int CLK_PERIOD = 10;
  localparam int SMP        = CLK_PERIOD / 2 - 1;
  localparam int DEPTH      = 8;
  localparam int CNT_W      = $clog2(DEPTH + 1);

  logic clk = 1'b0, rst = 1'b1;
  logic src_wr_valid = 1'b0, src_iack_req = 1'b0, dst_ready = 1'b0, irq_in = 1'b0;
  logic [PWB_ADDR_W-1:0] src_wr_addr = '0;
  logic [PWB_DATA_W-1:0] src_wr_data = '0;
  logic [PWB_BE_W-1:0]   src_wr_be = '0;
  logic src_wr_ack, src_iack_ack, dst_valid, dst_last, irq_out, stat_empty, stat_full;
  logic [PWB_ADDR_W-1:0] dst_addr;
  logic [PWB_DATA_W-1:0] dst_data;
  logic [PWB_BE_W-1:0]   dst_be;
  logic [CNT_W-1:0]      stat_count;

  int errors = 0, checks = 0;
  bit finished = 0;
  pwb_entry_t exp_q[$];

  always #(CLK_PERIOD / 2) clk = ~clk;

  posted_write_buffer #(.DEPTH(DEPTH)) u_posted_write_buffer (
    .clk, .rst, .src_wr_valid, .src_wr_addr, .src_wr_data, .src_wr_be, .src_wr_ack,
    .src_iack_req, .src_iack_ack, .dst_valid, .dst_ready, .dst_addr, .dst_data,
    .dst_be, .dst_last, .irq_in, .irq_out, .stat_empty, .stat_full, .stat_count
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // scoreboard monitor: one pop per completed handshake
  always @(negedge clk) begin
    #SMP;
    if (!rst && dst_valid && dst_ready) begin
      if (exp_q.size() == 0) chk("R4 unexpected beat", dst_addr, 32'hdead);
      else begin
        pwb_entry_t e;
        e = exp_q.pop_front();
        chk("R4 addr order", dst_addr, e.addr);
        chk("R4 data", dst_data, e.data);
        chk("R4 byte enables", 32'(dst_be), 32'(e.be));
      end
    end
  end

  task automatic post(input logic [31:0] a, input logic [31:0] d, input logic [3:0] b);
    pwb_entry_t e;
    @(negedge clk);
    src_wr_valid = 1'b1; src_wr_addr = a; src_wr_data = d; src_wr_be = b;
    #SMP;
    if (stat_count < CNT_W'(DEPTH)) chk("R1 immediate ack", 32'(src_wr_ack), 1);
    while (!src_wr_ack) begin
      @(negedge clk);
      #SMP;
    end
    e = '{addr: a, data: d, be: b};
    exp_q.push_back(e);
    @(posedge clk);
  endtask

  task automatic idle();
    @(negedge clk);
    src_wr_valid = 1'b0;
  endtask

  task automatic pop_one();
    @(negedge clk); dst_ready = 1'b1;
    @(negedge clk); dst_ready = 1'b0;
    #SMP;
  endtask

  function automatic logic [31:0] pat(input int i);
    return 32'h1357_9bdf ^ (32'(i) * 32'h0101_0101);
  endfunction

  initial begin
    #(CLK_PERIOD * 100000);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL R4 watchdog actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] last_exp [8];
    repeat (3) @(negedge clk);
    rst = 1'b0;
    #SMP;
    chk("R11 count after reset", 32'(stat_count), 0);
    chk("R11 empty after reset", 32'(stat_empty), 1);
    chk("R11 dst_valid after reset", 32'(dst_valid), 0);
    chk("R11 irq_out after reset", 32'(irq_out), 0);
    chk("R10 full after reset", 32'(stat_full), 0);

    // fill with sequential and non-sequential runs while the destination stalls
    post(32'h100, pat(1), 4'hf); post(32'h104, pat(2), 4'h3);
    post(32'h108, pat(3), 4'hc); post(32'h300, pat(4), 4'h1);
    idle(); #SMP;
    chk("R10 count four", 32'(stat_count), 4);
    chk("R10 not empty", 32'(stat_empty), 0);
    chk("R6 head continues burst", 32'(dst_last), 0);
    post(32'h500, pat(5), 4'hf); post(32'h504, pat(6), 4'hf);
    post(32'h508, pat(7), 4'h8); post(32'h50c, pat(8), 4'h2);
    idle(); #SMP;
    chk("R10 full flag", 32'(stat_full), 1);
    chk("R10 count full", 32'(stat_count), DEPTH);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk); #SMP;
      chk("R5 head held while stalled", dst_addr, 32'h100);
      chk("R5 valid held", 32'(dst_valid), 1);
    end

    // write while full and stalled: wait states
    @(negedge clk);
    src_wr_valid = 1'b1; src_wr_addr = 32'h600; src_wr_data = pat(9); src_wr_be = 4'h5;
    for (int i = 0; i < 3; i++) begin
      #SMP;
      chk("R2 no ack when full", 32'(src_wr_ack), 0);
      chk("R2 count unchanged", 32'(stat_count), DEPTH);
      @(negedge clk);
    end
    // same write with a drain in the same cycle
    dst_ready = 1'b1;
    #SMP;
    chk("R3 ack with simultaneous drain", 32'(src_wr_ack), 1);
    exp_q.push_back('{addr: 32'h600, data: pat(9), be: 4'h5});
    @(negedge clk);
    dst_ready = 1'b0; src_wr_valid = 1'b0;
    #SMP;
    chk("R3 count stays full", 32'(stat_count), DEPTH);

    // heads now 104,108,300,500,504,508,50c,600
    last_exp = '{0, 1, 1, 0, 0, 1, 1, 1};
    last_exp[5] = 0;
    for (int i = 0; i < 8; i++) begin
      chk($sformatf("R6 last flag step %0d", i), 32'(dst_last), last_exp[i]);
      pop_one();
    end
    chk("R10 empty after drain", 32'(stat_empty), 1);
    chk("R4 no valid when empty", 32'(dst_valid), 0);

    // interrupt ordering behind three posted writes
    post(32'h700, pat(10), 4'hf); post(32'h704, pat(11), 4'hf); post(32'h708, pat(12), 4'hf);
    idle();
    @(negedge clk); irq_in = 1'b1;
    post(32'h800, pat(13), 4'hf); post(32'h900, pat(14), 4'hf);
    idle(); #SMP;
    chk("R7 irq held behind writes", 32'(irq_out), 0);
    pop_one(); chk("R7 irq held after one drain", 32'(irq_out), 0);
    pop_one(); chk("R7 irq held after two drains", 32'(irq_out), 0);
    pop_one(); chk("R7 irq after earlier writes drained", 32'(irq_out), 1);
    chk("R7 later writes still stored", 32'(stat_count), 2);
    @(negedge clk); irq_in = 1'b0;
    @(negedge clk); #SMP;
    chk("R8 irq withdrawn", 32'(irq_out), 0);

    // interrupt acknowledge while two writes remain
    @(negedge clk); src_iack_req = 1'b1;
    for (int i = 0; i < 3; i++) begin
      #SMP;
      chk("R9 iack wait state", 32'(src_iack_ack), 0);
      @(negedge clk);
    end
    dst_ready = 1'b1;
    #SMP;
    for (int i = 0; i < 20 && !src_iack_ack; i++) begin
      @(negedge clk); #SMP;
    end
    chk("R9 iack completes", 32'(src_iack_ack), 1);
    chk("R9 iack only when empty", 32'(stat_empty), 1);
    @(negedge clk); src_iack_req = 1'b0; dst_ready = 1'b0;

    // interrupt with nothing ahead
    @(negedge clk); irq_in = 1'b1; #SMP;
    chk("R7 not yet captured", 32'(irq_out), 0);
    @(negedge clk); #SMP;
    chk("R7 immediate irq when empty", 32'(irq_out), 1);
    @(negedge clk); irq_in = 1'b0;

    // mixed traffic with a stalling destination
    begin
      bit wdone = 0;
      fork
        begin
          for (int i = 0; i < 40; i++)
            post((i % 5 == 0) ? 32'h2000 + 32'(i) * 32'h40 : 32'h1000 + 32'(i) * 4,
                 pat(100 + i), 4'(i) | 4'h1);
          idle();
          wdone = 1;
        end
        begin
          int k = 0;
          while (!wdone) begin
            @(negedge clk);
            dst_ready = (k % 3 != 0);
            k++;
          end
        end
      join
    end
    @(negedge clk); dst_ready = 1'b1;
    for (int i = 0; i < 50 && !stat_empty; i++) @(negedge clk);
    #SMP;
    chk("R4 every entry drained", 32'(exp_q.size()), 0);
    chk("R10 empty at end", 32'(stat_empty), 1);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule